// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write side and read side run on separate, unrelated clocks. Words go in on the write clock and come out on the read clock in the order they were written. Each clock domain receives a copy of the other side's pointer as a Gray code passed through two flops. Each status flag is computed in the domain that uses it.

Two timing modes are available, and the mode is chosen while the master reset is held. In standard mode a read request fetches the next word into the output register. In fall-through mode the oldest word is moved to the output without a request, and a read request consumes it. The two shared status outputs change meaning with the mode. In standard mode they are empty and full flags. In fall-through mode they are output-ready and input-ready indicators. The block also has a half-full flag and two programmable threshold flags. The almost-empty and almost-full thresholds are separate offset inputs that are driven by an external offset-register block.

A partial reset empties the buffer and keeps the latched mode. A retransmit strobe moves the read pointer back to the first memory location, so that the data written since the last reset can be read again.

Top module: `afifo_pflag`

## Requirements
- R1: In standard mode, a read request sampled at a read-clock edge while words are stored puts the oldest word on dout_o after that edge. Words leave in the order they were written.
- R2: In standard mode, empty_or_o is 1 when no word is stored, and full_ir_o is 1 when DEPTH = 2^ADDR_W words are stored.
- R3: A write request while the memory is full is ignored, and a read request while nothing is stored is ignored. Neither pointer moves, so the stored contents and the flags are unchanged.
- R4: hf_o is 1 when the memory holds more than DEPTH/2 words.
- R5: ae_o is 1 when the number of stored words, counting the fall-through output word, is less than or equal to ae_off_i.
- R6: af_o is 1 when the free space in memory (DEPTH minus the words in memory) is less than or equal to af_off_i.
- R7: While rst_ni is low, both pointers and the output register are cleared and the mode is loaded from fwft_sel_i (0 = standard, 1 = fall-through). After release the buffer is empty.
- R8: In fall-through mode, empty_or_o is 1 while dout_o holds an unread word, and full_ir_o is 1 while the memory can accept a write. The oldest word reaches dout_o with no read request. It stays there until a read request consumes it, and the next word then takes its place. The output word is not counted by full_ir_o, hf_o or af_o, so the buffer holds DEPTH+1 words.
- R9: While part_rst_ni is low, the pointers and the output register are cleared and the latched mode is kept. The flags then show an empty buffer in that mode.
- R10: If rt_ni is low at a rising read-clock edge, the read pointer returns to location 0, any fall-through output word is discarded, and reading starts again from the first word written since the last reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| part_rst_ni | input | 1 | Partial reset, asynchronous, active low |
| fwft_sel_i | input | 1 | Mode select, loaded during master reset |
| wen_i | input | 1 | Write request |
| din_i | input | DATA_W | Write data |
| ren_i | input | 1 | Read request |
| rt_ni | input | 1 | Retransmit strobe, active low |
| ae_off_i | input | ADDR_W | Almost-empty threshold |
| af_off_i | input | ADDR_W | Almost-full threshold |
| dout_o | output | DATA_W | Read data |
| empty_or_o | output | 1 | Empty (standard) or output ready (fall-through) |
| full_ir_o | output | 1 | Full (standard) or input ready (fall-through) |
| hf_o | output | 1 | Half full |
| ae_o | output | 1 | Almost empty |
| af_o | output | 1 | Almost full |

## Verification
Flags in the domain that made the change move right after that clock edge. Flags in the other domain move after one Gray register and two synchronizer flops, which is up to four cycles of the other clock. A fall-through word reaches dout_o one read edge after that. The bench therefore waits six cycles of each clock after every write, read, reset or retransmit, and it samples 1 ns away from both clocks' edges before it compares all five flags. Standard-mode read data is due at the first read edge after the request, and the bench checks it on the following falling read-clock edge.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} mode_e;

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 11
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/afifo_wr_ctrl.sv
module afifo_wr_ctrl
  import afifo_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic              wen_i,
  input  logic [ADDR_W:0]   rgray_i,
  input  logic [ADDR_W-1:0] af_off_i,
  output logic [ADDR_W:0]   wgray_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              we_o,
  output logic              full_ir_o,
  output logic              hf_o,
  output logic              af_o
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, rbin, wcnt;
  logic          full;

  assign rbin   = PW'(gray2bin(32'(rgray_i)));
  assign wcnt   = wbin_q - rbin;
  assign full   = (wcnt == PW'(DEPTH));
  assign we_o   = wen_i & ~full;
  assign wbin_d = wbin_q + PW'(we_o);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wbin_d ^ (wbin_d >> 1);
    end
  end

  assign wgray_o   = wgray_q;
  assign waddr_o   = wbin_q[ADDR_W-1:0];
  assign full_ir_o = (mode_i == MODE_FWFT) ? ~full : full;
  assign hf_o      = wcnt > PW'(DEPTH / 2);
  assign af_o      = (PW'(DEPTH) - wcnt) <= {1'b0, af_off_i};

  p_no_overflow_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wcnt <= PW'(DEPTH));
  p_full_blocks_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (full && wen_i) |=> (wbin_q == $past(wbin_q)));
endmodule

// File: rtl/afifo_rd_ctrl.sv
module afifo_rd_ctrl
  import afifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 11
) (
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic              ren_i,
  input  logic              rt_ni,
  input  logic [ADDR_W:0]   wgray_i,
  input  logic [ADDR_W-1:0] ae_off_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [ADDR_W:0]   rgray_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              empty_or_o,
  output logic              ae_o
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     rbin_q, rbin_d, rgray_q, wbin, rcnt, total;
  logic [DATA_W-1:0] dout_q;
  logic              ovalid_q, fwft, has_word, take;

  assign fwft     = (mode_i == MODE_FWFT);
  assign wbin     = PW'(gray2bin(32'(wgray_i)));
  assign rcnt     = wbin - rbin_q;
  assign has_word = (rcnt != '0);
  // fall-through refills the output register whenever it is free or being consumed
  assign take     = has_word & (fwft ? (~ovalid_q | ren_i) : ren_i);
  assign rbin_d   = !rt_ni ? '0 : rbin_q + PW'(take);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      dout_q   <= '0;
      ovalid_q <= 1'b0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
      if (!rt_ni) begin
        ovalid_q <= 1'b0;
      end else begin
        if (take) dout_q <= rdata_i;
        if (fwft) ovalid_q <= take | (ovalid_q & ~ren_i);
      end
    end
  end

  assign total      = rcnt + PW'(fwft & ovalid_q);
  assign raddr_o    = rbin_q[ADDR_W-1:0];
  assign rgray_o    = rgray_q;
  assign dout_o     = dout_q;
  assign empty_or_o = fwft ? ovalid_q : ~has_word;
  assign ae_o       = total <= {1'b0, ae_off_i};

  p_no_underflow_r3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rt_ni && wbin == rbin_q) |=> (rbin_q == $past(rbin_q)));
  p_rt_rewind_r10: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rt_ni |=> (rbin_q == '0));
  p_or_hold_r8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (fwft && ovalid_q && !ren_i && rt_ni) |=> (ovalid_q && $stable(dout_q)));
endmodule

// File: rtl/afifo_pflag.sv
module afifo_pflag
  import afifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 11
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              part_rst_ni,
  input  logic              fwft_sel_i,
  input  logic              wen_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ren_i,
  input  logic              rt_ni,
  input  logic [ADDR_W-1:0] ae_off_i,
  input  logic [ADDR_W-1:0] af_off_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              empty_or_o,
  output logic              full_ir_o,
  output logic              hf_o,
  output logic              ae_o,
  output logic              af_o
);
  localparam int PW = ADDR_W + 1;

  logic              ptr_rst_n, we;
  mode_e             mode_w_q, mode_r_q;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] rdata;

  assign ptr_rst_n = rst_ni & part_rst_ni;

  // mode follows fwft_sel_i while master reset is held; partial reset leaves it
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) mode_w_q <= mode_e'(fwft_sel_i);
  end
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) mode_r_q <= mode_e'(fwft_sel_i);
  end

  afifo_sync #(.W(PW)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(ptr_rst_n), .d_i(wgray), .q_o(wgray_s));
  afifo_sync #(.W(PW)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(ptr_rst_n), .d_i(rgray), .q_o(rgray_s));

  afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(din_i),
    .raddr_i(raddr), .rdata_o(rdata));

  afifo_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .wclk_i(wclk_i), .rst_ni(ptr_rst_n), .mode_i(mode_w_q), .wen_i(wen_i),
    .rgray_i(rgray_s), .af_off_i(af_off_i), .wgray_o(wgray), .waddr_o(waddr),
    .we_o(we), .full_ir_o(full_ir_o), .hf_o(hf_o), .af_o(af_o));

  afifo_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rclk_i(rclk_i), .rst_ni(ptr_rst_n), .mode_i(mode_r_q), .ren_i(ren_i),
    .rt_ni(rt_ni), .wgray_i(wgray_s), .ae_off_i(ae_off_i), .rdata_i(rdata),
    .raddr_o(raddr), .rgray_o(rgray), .dout_o(dout_o),
    .empty_or_o(empty_or_o), .ae_o(ae_o));
endmodule

// File: tb/tb_afifo_pflag.sv
`timescale 1ns/100ps
module tb_afifo_pflag;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int AE = 3;
  localparam int AF = 2;

  logic wclk = 1'b0, rclk = 1'b1;
  logic rst_n = 1'b0, prst_n = 1'b1, fsel = 1'b0;
  logic wen = 1'b0, ren = 1'b0, rt_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic eo, fi, hf, ae, af;

  int checks = 0, errors = 0;
  int mwp = 0, mrp = 0;
  bit fwft = 1'b0;
  logic [DW-1:0] mdata [64];

  always #2 wclk = ~wclk;
  always #2 rclk = ~rclk;

  afifo_pflag #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .part_rst_ni(prst_n),
    .fwft_sel_i(fsel), .wen_i(wen), .din_i(din), .ren_i(ren), .rt_ni(rt_n),
    .ae_off_i(AW'(AE)), .af_off_i(AW'(AF)), .dout_o(dout),
    .empty_or_o(eo), .full_ir_o(fi), .hf_o(hf), .ae_o(ae), .af_o(af));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge wclk);
    #1;
  endtask

  task automatic check_flags(input string tag);
    int tot, mc;
    bit ov, e_eo, e_fi;
    tot  = mwp - mrp;
    ov   = fwft && tot > 0;
    mc   = tot - int'(ov);
    e_eo = fwft ? (tot > 0) : (tot == 0);
    e_fi = fwft ? (mc < DEPTH) : (mc == DEPTH);
    chk(eo == e_eo, fwft ? {"R8 ready-out ", tag} : {"R2 empty ", tag}, eo, e_eo);
    chk(fi == e_fi, fwft ? {"R8 ready-in ", tag} : {"R2 full ", tag}, fi, e_fi);
    chk(hf == (mc > DEPTH / 2), {"R4 half ", tag}, hf, mc > DEPTH / 2);
    chk(ae == (tot <= AE), {"R5 ae ", tag}, ae, tot <= AE);
    chk(af == ((DEPTH - mc) <= AF), {"R6 af ", tag}, af, (DEPTH - mc) <= AF);
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    @(negedge wclk);
    wen = 1'b1;
    din = d;
    @(negedge wclk);
    wen = 1'b0;
    if ((mwp - mrp) < (fwft ? DEPTH + 1 : DEPTH)) begin
      mdata[mwp] = d;
      mwp++;
    end
  endtask

  task automatic do_read(input string req);
    logic [DW-1:0] exp;
    bit had;
    had = (mwp - mrp) > 0;
    exp = had ? mdata[mrp] : '0;
    @(negedge rclk);
    ren = 1'b1;
    @(negedge rclk);
    ren = 1'b0;
    if (had) begin
      mrp++;
      if (!fwft) chk(dout == exp, req, dout, exp);
    end
  endtask

  task automatic master_reset(input bit sel);
    rst_n = 1'b0;
    fsel  = sel;
    #10;
    rst_n = 1'b1;
    #1 fsel = ~sel;
    mwp = 0; mrp = 0; fwft = sel;
    settle();
  endtask

  task automatic partial_reset();
    prst_n = 1'b0;
    #10;
    prst_n = 1'b1;
    mwp = 0; mrp = 0;
    settle();
  endtask

  task automatic retransmit();
    @(negedge rclk);
    rt_n = 1'b0;
    @(negedge rclk);
    rt_n = 1'b1;
    mrp = 0;
    settle();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R7: master reset, standard mode
    #21;
    rst_n = 1'b1;
    mwp = 0; mrp = 0; fwft = 1'b0;
    settle();
    check_flags("R7 reset");
    chk(dout == '0, "R7 dout cleared", dout, 0);

    // standard fill sweep; last write is refused (R3)
    for (int i = 0; i <= DEPTH; i++) begin
      do_write(DW'(i * 37 + 5));
      settle();
      check_flags($sformatf("fill n=%0d", i + 1));
    end
    // drain sweep: order and flags (R1)
    for (int i = 0; i < DEPTH; i++) begin
      do_read("R1 order");
      settle();
      check_flags($sformatf("drain n=%0d", i));
    end
    // R3: read while empty leaves pointer alone
    do_read("R3 empty read");
    settle();
    check_flags("R3 after empty read");
    do_write(9'h055);
    settle();
    do_read("R3 next word after empty read");
    settle();

    // R9 then R10 in standard mode
    do_write(9'h101);
    settle();
    partial_reset();
    check_flags("R9 std partial");
    for (int i = 0; i < 5; i++) do_write(DW'(9'h0a0 + i));
    settle();
    for (int i = 0; i < 3; i++) do_read("R1 pre-rt");
    settle();
    retransmit();
    check_flags("R10 std rt");
    for (int i = 0; i < 5; i++) do_read("R10 reread std");
    settle();

    // R7/R8: master reset into fall-through mode
    do_write(9'h033);
    settle();
    master_reset(1'b1);
    check_flags("R7 fwft reset");
    for (int i = 0; i <= DEPTH + 1; i++) begin
      do_write(DW'(i * 11 + 2));
      settle();
      check_flags($sformatf("fwft fill n=%0d", i + 1));
      chk(dout == mdata[0], "R8 head word shown", dout, mdata[0]);
    end
    for (int i = 0; i <= DEPTH; i++) begin
      chk(dout == mdata[mrp], "R8 fall-through data", dout, mdata[mrp]);
      do_read("R8");
      settle();
      check_flags($sformatf("fwft drain n=%0d", i));
    end

    // R9: partial reset keeps fall-through mode
    for (int i = 0; i < 3; i++) do_write(DW'(9'h1c0 + i));
    settle();
    partial_reset();
    check_flags("R9 fwft partial");
    do_write(9'h07e);
    do_write(9'h07f);
    settle();
    chk(dout == 9'h07e, "R9 fwft head after partial", dout, 9'h07e);
    check_flags("R9 fwft after writes");

    // R10: retransmit in fall-through mode
    do_read("R10 consume");
    settle();
    chk(dout == 9'h07f, "R10 second word", dout, 9'h07f);
    retransmit();
    chk(dout == 9'h07e, "R10 fwft reread head", dout, 9'h07e);
    check_flags("R10 fwft rt");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule